// File: doc/BRIEF.md
# Late-Write Synchronous Burst SRAM

This block is a synthesizable model of a synchronous static RAM whose write data trails its write command. Because of that lag, read and write commands can follow each other on every clock with no idle cycle between them. One clock edge captures the address, the read/write select, the byte write enables, three chip selects and a load/advance control. A static mode input chooses one of two timings. In pipelined timing, read data passes through an output register. In flow-through timing, read data comes straight from the array.

A load command opens a four-beat burst. Each following advance cycle steps the two low address bits, either counting upward or by XOR, and the burst stays inside its four-word block. The read data port carries its own drive-enable flag. The output-enable and sleep inputs act on that flag combinationally, with no clock. When a read reaches an address whose late write has not yet landed in the array, it returns the newer data, merged byte by byte.

Top module: `lw_burst_sram`

## Requirements
- R1: With `pipe_mode`=1, a read captured at clock edge k drives its word on `q_out` with `q_drive`=1 between edges k+1 and k+2.
- R2: With `pipe_mode`=0, a read captured at edge k drives its word between edges k and k+1.
- R3: Write data on `d_in` is taken at edge k+2 (pipelined) or k+1 (flow-through) for a write captured at edge k.
- R4: Read and write commands in any order on consecutive cycles each complete correctly, with no idle cycle needed between them.
- R5: With `lin_order`=1, beat n of a burst (n = 0,1,2,3, then wrapping) uses low address bits (start + n) mod 4 and keeps the upper address bits of the load.
- R6: With `lin_order`=0, beat n uses low address bits start XOR n.
- R7: `bw_n[i]`=0 writes byte i, which is bits [9i+8:9i] of the word. A byte whose `bw_n` bit is 1 keeps its stored value.
- R8: A load cycle (`adv`=0) is selected only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. Any other combination is a deselect: nothing is written, nothing is driven, and any burst in progress ends.
- R9: While `oe_n`=1, `q_drive` is 0 without waiting for a clock edge.
- R10: While `sleep`=1, commands sampled at the clock edge are ignored, a burst in progress neither advances nor ends, and `q_drive` is 0.
- R11: In pipelined mode, a read that immediately follows a write to the same address returns the new bytes merged over the old ones.
- R12: After reset, and on any advance cycle with no burst open, `q_drive` stays 0. Whenever `q_drive`=0, `q_out` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pipe_mode | input | 1 | 1 = pipelined timing, 0 = flow-through; change only under reset |
| lin_order | input | 1 | 1 = linear burst order, 0 = XOR order |
| sleep | input | 1 | Blocks new commands and disables the read drive |
| oe_n | input | 1 | Active-low output enable, combinational |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 = load a new command, 1 = advance the open burst |
| we_n | input | 1 | 0 = write, 1 = read (on load cycles) |
| bw_n | input | 2 | Active-low byte write enables |
| addr | input | 6 | Word address |
| d_in | input | 18 | Write data bus |
| q_out | output | 18 | Read data, 0 when not driving |
| q_drive | output | 1 | Read data drive enable |

## Verification
The hardest case to reach is a pipelined read that lands on a word whose write is still waiting for its data. This happens only when the read is captured exactly one edge after the write, with the same address. The bench produces it by alternating single-beat writes and reads to the same address on back-to-back cycles under varied byte masks. A per-edge reference model then recomputes the memory image and the expected bus word independently. Sweeps over every block, every start offset, both orders and both timings cover the wrap of a fifth advance beat.

// File: rtl/lwb_pkg.sv
`timescale 1ns/1ps
package lwb_pkg;
    localparam int ADDR_W = 6;
    localparam int NBYTE  = 2;
    localparam int BYTE_W = 9;
    localparam int BEAT_W = 2;
    localparam int DATA_W = NBYTE * BYTE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [NBYTE-1:0]  ben_t;
    typedef logic [BEAT_W-1:0] beat_t;

    // One captured access: valid, write flag, word address, active-high byte mask
    typedef struct packed {
        logic  vld;
        logic  wr;
        addr_t addr;
        ben_t  be;
    } acc_t;

    function automatic beat_t beat_low(input logic lin, input beat_t start, input beat_t cnt);
        return lin ? beat_t'(start + cnt) : (start ^ cnt);
    endfunction

    function automatic word_t merge_bytes(input word_t old_w, input word_t new_w, input ben_t be);
        word_t r;
        r = old_w;
        for (int b = 0; b < NBYTE; b++) begin
            if (be[b]) r[b*BYTE_W +: BYTE_W] = new_w[b*BYTE_W +: BYTE_W];
        end
        return r;
    endfunction
endpackage

// File: rtl/lwb_cmd_ctrl.sv
`timescale 1ns/1ps
module lwb_cmd_ctrl
    import lwb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sleep,
    input  logic  lin_order,
    input  logic  cs0_n,
    input  logic  cs1,
    input  logic  cs2_n,
    input  logic  adv,
    input  logic  we_n,
    input  ben_t  bw_n,
    input  addr_t addr,
    output acc_t  cmd_q
);
    logic  sel;
    logic  b_on;
    logic  b_wr;
    addr_t b_base;
    beat_t b_cnt;
    addr_t adv_addr;

    assign sel = !cs0_n && cs1 && !cs2_n;

    always_comb begin
        adv_addr = b_base;
        adv_addr[BEAT_W-1:0] = beat_low(lin_order, b_base[BEAT_W-1:0], b_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            b_on   <= 1'b0;
            b_wr   <= 1'b0;
            b_base <= '0;
            b_cnt  <= '0;
        end else begin
            cmd_q <= '0;
            if (!sleep) begin
                if (!adv) begin
                    if (sel) begin
                        b_on   <= 1'b1;
                        b_wr   <= !we_n;
                        b_base <= addr;
                        b_cnt  <= beat_t'(1);
                        cmd_q  <= '{vld: 1'b1, wr: !we_n, addr: addr, be: ~bw_n};
                    end else begin
                        b_on <= 1'b0;
                    end
                end else if (b_on) begin
                    b_cnt <= b_cnt + beat_t'(1);
                    cmd_q <= '{vld: 1'b1, wr: b_wr, addr: adv_addr, be: ~bw_n};
                end
            end
        end
    end

    assert_sleep_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        sleep |=> !cmd_q.vld);

    assert_deselect_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !adv && !sel) |=> !cmd_q.vld);

    assert_burst_in_block_R5: assert property (@(posedge clk) disable iff (rst)
        (!sleep && adv && cmd_q.vld) |=>
            (cmd_q.vld && cmd_q.addr[ADDR_W-1:BEAT_W] == $past(cmd_q.addr[ADDR_W-1:BEAT_W])));
endmodule

// File: rtl/lwb_store.sv
`timescale 1ns/1ps
module lwb_store
    import lwb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  acc_t  wr_acc,
    input  word_t wdata,
    input  addr_t rd_addr,
    output word_t rd_data
);
    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst && wr_acc.vld && wr_acc.wr) begin
            for (int b = 0; b < NBYTE; b++) begin
                if (wr_acc.be[b]) mem[wr_acc.addr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/lwb_out_stage.sv
`timescale 1ns/1ps
module lwb_out_stage
    import lwb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pipe_mode,
    input  logic  sleep,
    input  logic  oe_n,
    input  acc_t  s1,
    input  word_t rd_now,
    output acc_t  s2_q,
    output word_t q_out,
    output logic  q_drive
);
    logic  out_vld;
    word_t out_q;
    logic  rd_act;
    word_t sel_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q    <= '0;
            out_vld <= 1'b0;
            out_q   <= '0;
        end else begin
            s2_q    <= s1;
            out_vld <= s1.vld && !s1.wr;
            out_q   <= rd_now;
        end
    end

    always_comb begin
        rd_act   = pipe_mode ? out_vld : (s1.vld && !s1.wr);
        sel_data = pipe_mode ? out_q : rd_now;
        q_drive  = rd_act && !oe_n && !sleep;
        q_out    = q_drive ? sel_data : '0;
    end

    assert_pipe_latency_R1: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && s1.vld && !s1.wr) |=> (q_drive || oe_n || sleep));

    assert_pipe_no_stray_R12: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && !$past(s1.vld && !s1.wr)) |-> !q_drive);
endmodule

// File: rtl/lw_burst_sram.sv
`timescale 1ns/1ps
module lw_burst_sram
    import lwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pipe_mode,
    input  logic              lin_order,
    input  logic              sleep,
    input  logic              oe_n,
    input  logic              cs0_n,
    input  logic              cs1,
    input  logic              cs2_n,
    input  logic              adv,
    input  logic              we_n,
    input  logic [NBYTE-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] q_out,
    output logic              q_drive
);
    acc_t  s1;
    acc_t  s2;
    acc_t  commit;
    word_t raw_rd;
    word_t rd_now;
    logic  fwd_hit;

    lwb_cmd_ctrl u_ctrl (
        .clk(clk), .rst(rst), .sleep(sleep), .lin_order(lin_order),
        .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .adv(adv), .we_n(we_n),
        .bw_n(bw_n), .addr(addr), .cmd_q(s1)
    );

    // Late write: data arrives one edge (flow) or two edges (pipelined) after the command
    assign commit = pipe_mode ? s2 : s1;

    lwb_store u_store (
        .clk(clk), .rst(rst), .wr_acc(commit), .wdata(d_in),
        .rd_addr(s1.addr), .rd_data(raw_rd)
    );

    // A pipelined read sampled at the same edge as a pending write's data sees the new bytes
    always_comb begin
        fwd_hit = pipe_mode && s2.vld && s2.wr && (s2.addr == s1.addr);
        rd_now  = fwd_hit ? merge_bytes(raw_rd, d_in, s2.be) : raw_rd;
    end

    lwb_out_stage u_out (
        .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .sleep(sleep), .oe_n(oe_n),
        .s1(s1), .rd_now(rd_now), .s2_q(s2), .q_out(q_out), .q_drive(q_drive)
    );

    assert_write_lag_R3: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && s1.vld && s1.wr) |=> (s2.vld && s2.wr && s2.addr == $past(s1.addr)));
endmodule

// File: tb/lw_burst_sram_tb.sv
`timescale 1ns/1ps
module lw_burst_sram_tb;
    import lwb_pkg::*;

    localparam logic [2:0] SEL = 3'b010;
    localparam logic [2:0] DES = 3'b110;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1, pipe_mode = 1'b1, lin_order = 1'b1, sleep = 1'b0, oe_n = 1'b0;
    logic cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1, adv = 1'b0, we_n = 1'b1;
    ben_t  bw_n = '1;
    addr_t addr = '0;
    word_t d_in = '0;
    word_t q_out;
    logic  q_drive;

    lw_burst_sram u_dut (
        .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .lin_order(lin_order), .sleep(sleep),
        .oe_n(oe_n), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .adv(adv), .we_n(we_n),
        .bw_n(bw_n), .addr(addr), .d_in(d_in), .q_out(q_out), .q_drive(q_drive)
    );

    int n_chk = 0, n_err = 0, gcyc = 0;
    bit done = 0;

    word_t ref_mem [DEPTH];
    acc_t  p1, p2;
    logic  b_on, b_wr;
    addr_t b_base;
    beat_t b_cnt;
    logic  exp_v;
    word_t exp_d;

    task automatic model_edge();
        acc_t c, nw, r;
        beat_t lo;
        nw = '0;
        c = pipe_mode ? p2 : p1;
        if (c.vld && c.wr)
            for (int b = 0; b < NBYTE; b++)
                if (c.be[b]) ref_mem[c.addr][b*BYTE_W +: BYTE_W] = d_in[b*BYTE_W +: BYTE_W];
        if (!sleep) begin
            if (!adv) begin
                if ({cs0_n, cs1, cs2_n} == SEL) begin
                    b_on = 1; b_wr = !we_n; b_base = addr; b_cnt = 2'd1;
                    nw.vld = 1; nw.wr = !we_n; nw.addr = addr; nw.be = ~bw_n;
                end else b_on = 0;
            end else if (b_on) begin
                lo = lin_order ? beat_t'(b_base[1:0] + b_cnt) : (b_base[1:0] ^ b_cnt);
                nw.vld = 1; nw.wr = b_wr; nw.addr = {b_base[ADDR_W-1:2], lo}; nw.be = ~bw_n;
                b_cnt = b_cnt + 2'd1;
            end
        end
        r = pipe_mode ? p1 : nw;
        exp_v = r.vld && !r.wr;
        exp_d = ref_mem[r.addr];
        p2 = p1;
        p1 = nw;
    endtask

    task automatic check_bus(input string tag);
        logic  ev;
        word_t ed;
        ev = exp_v && !oe_n && !sleep;
        ed = ev ? exp_d : '0;
        n_chk++;
        if (q_drive !== ev || q_out !== ed) begin
            n_err++;
            $display("FAIL %s: drive=%b data=%h expected drive=%b data=%h", tag, q_drive, q_out, ev, ed);
        end
    endtask

    task automatic step(input string tag, input logic a_adv, input logic [2:0] cs,
                        input logic a_we_n, input ben_t a_bw_n, input addr_t a_addr);
        adv = a_adv; {cs0_n, cs1, cs2_n} = cs; we_n = a_we_n; bw_n = a_bw_n; addr = a_addr;
        d_in = DATA_W'(gcyc * 691 + 83);
        #1;
        check_bus(tag);
        @(posedge clk);
        model_edge();
        gcyc++;
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1'b0, DES, 1'b1, '1, '0);
    endtask
    task automatic ld_wr(input string tag, input addr_t a, input ben_t m);
        step(tag, 1'b0, SEL, 1'b0, m, a);
    endtask
    task automatic ld_rd(input string tag, input addr_t a);
        step(tag, 1'b0, SEL, 1'b1, '1, a);
    endtask
    task automatic advc(input string tag);
        step(tag, 1'b1, DES, 1'b1, '0, '0);
    endtask

    task automatic do_reset(input logic pm, input logic lo);
        rst = 1; pipe_mode = pm; lin_order = lo; oe_n = 0; sleep = 0;
        adv = 0; {cs0_n, cs1, cs2_n} = DES; we_n = 1; bw_n = '1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        p1 = '0; p2 = '0; b_on = 0; b_wr = 0; b_base = '0; b_cnt = '0; exp_v = 0; exp_d = '0;
    endtask

    initial begin
        @(negedge clk);
        // R12: reset state and advance with no open burst
        do_reset(1, 1);
        idle("R12 reset", 2);
        for (int i = 0; i < 3; i++) advc("R12 stray advance");

        // R1 R2 R3 R5 R6: full sweeps over every block, start offset, order and timing
        for (int pm = 1; pm >= 0; pm--) begin
            for (int lo = 1; lo >= 0; lo--) begin
                do_reset(pm[0], lo[0]);
                for (int blk = 0; blk < DEPTH/4; blk++) begin
                    ld_wr(lo ? "R5 R3 write burst" : "R6 R3 write burst", addr_t'(blk*4 + blk%4), '0);
                    for (int k = 0; k < 3; k++) advc(lo ? "R5 R3 write burst" : "R6 R3 write burst");
                end
                idle("R3 flush", 2);
                for (int blk = 0; blk < DEPTH/4; blk++) begin
                    ld_rd(pm ? (lo ? "R1 R5 read" : "R1 R6 read") : (lo ? "R2 R5 read" : "R2 R6 read"),
                          addr_t'(blk*4 + (blk+1)%4));
                    for (int k = 0; k < 4; k++)
                        advc(pm ? (lo ? "R1 R5 wrap" : "R1 R6 wrap") : (lo ? "R2 R5 wrap" : "R2 R6 wrap"));
                end
                idle("R1 R2 drain", 2);
            end
        end

        // R4 R7 R11: alternating write/read on back-to-back cycles, same address
        for (int pm = 1; pm >= 0; pm--) begin
            do_reset(pm[0], 1);
            for (int i = 0; i < 40; i++) begin
                if (i % 2 == 0) ld_wr("R4 R7 R11 mixed", addr_t'((i*11) % DEPTH), ben_t'(i/2 % 4));
                else            ld_rd("R4 R11 mixed", addr_t'(((i-1)*11) % DEPTH));
            end
            idle("R4 drain", 3);
        end

        // R7: every byte mask
        do_reset(1, 1);
        for (int m = 0; m < 4; m++) begin
            ld_wr("R7 mask", addr_t'(5), ben_t'(m));
            idle("R7 gap", 1);
            ld_rd("R7 readback", addr_t'(5));
            idle("R7 drain", 2);
        end

        // R8: every chip select combination on write and read
        for (int c = 0; c < 8; c++) begin
            step("R8 write select", 1'b0, c[2:0], 1'b0, '0, addr_t'(9 + c));
            idle("R8 gap", 1);
            ld_rd("R8 readback", addr_t'(9 + c));
            step("R8 read select", 1'b0, c[2:0], 1'b1, '1, addr_t'(9 + c));
            advc("R8 advance after select");
            idle("R8 drain", 2);
        end

        // R9: output enable toggled between edges, plus a mid-cycle change
        for (int pm = 1; pm >= 0; pm--) begin
            do_reset(pm[0], 0);
            for (int i = 0; i < 16; i++) begin
                oe_n = (i % 3 == 1);
                if (i % 4 == 0) ld_rd("R9 oe pattern", addr_t'(i*3));
                else            advc("R9 oe pattern");
            end
            oe_n = 0;
            idle("R9 drain", 2);
        end
        do_reset(1, 1);
        ld_rd("R9 setup", addr_t'(12));
        idle("R9 setup", 1);
        #1;
        check_bus("R9 before change");
        oe_n = 1; #1;
        check_bus("R9 mid-cycle off");
        oe_n = 0; #1;
        check_bus("R9 mid-cycle on");
        idle("R9 drain", 2);

        // R10: sleep blocks commands, freezes bursts and turns the drive off
        for (int pm = 1; pm >= 0; pm--) begin
            do_reset(pm[0], 1);
            ld_rd("R10 burst start", addr_t'(20));
            advc("R10 burst");
            sleep = 1;
            advc("R10 frozen advance");
            ld_wr("R10 ignored write", addr_t'(20), '0);
            ld_rd("R10 ignored read", addr_t'(21));
            sleep = 0;
            advc("R10 resume burst");
            advc("R10 resume burst");
            idle("R10 drain", 2);
            ld_rd("R10 data kept", addr_t'(20));
            idle("R10 drain", 2);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule